// File: doc/BRIEF.md
# Glitch-Free Clock Output Gate Controller

This block decides whether a synthesized clock reaches an output pin. Two pin-level controls act on it: an active-low power-down input and an active-high output-enable input. Power-down asks the oscillator and PLL to enter standby and releases the pin to a weak pull toward ground. Output-disable releases the pin in the same way, but the clock source keeps running, so the clock returns quickly when the output is enabled again.

A static configuration bit picks one of two timing modes. In the immediate mode, control changes reach the pin after logic delay only, at any phase of the clock, so partial pulses can appear. In the aligned mode, both controls pass through a two-stage synchronizer on the falling edge, and the output state register also changes only on the falling edge. The pin state therefore never changes while the clock is high, and no high phase is ever cut short.

Leaving power-down starts a relock model: a counter of reference clock cycles. Until it expires the pin is driven low and the output-enable input has no effect.

Top module: `clk_gate_ctl`

## Requirements
- R1: While power-down is in effect, standby_req is 1, drv_en is 0, pull_low is 1, clk_out is 0 and pll_locked is cleared at the next rising edge of clk_ref.
- R2: While out_en is 0 after lock, with power-down not in effect, drv_en is 0, pull_low is 1, clk_out is 0, standby_req is 0 and pll_locked stays 1.
- R3: With cfg_sync_mode = 0, a change on pwr_dn_n or out_en reaches clk_out, drv_en and standby_req without waiting for any clock edge, even in the middle of a high phase.
- R4: With cfg_sync_mode = 1, a control change takes effect at the third falling edge of clk_ref after it, the output state never changes while clk_ref is high, and no high phase of clk_out is shorter than the high phase of clk_ref.
- R5: With cfg_sync_mode = 1, the first clk_out pulse after output-enable returns to 1 is a complete high phase of clk_ref.
- R6: After power-down ends, drv_en is 1 and clk_out stays 0 until pll_locked rises, and pll_locked rises at the LOCK_CYCLES-th rising edge of clk_ref that sees standby_req at 0.
- R7: When power-down is in effect, out_en = 1 does not enable the pin, including when both inputs change together.
- R8: While pll_locked is 0 and power-down is not in effect, out_en has no effect: drv_en stays 1 and pull_low stays 0.
- R9: drv_en and pull_low are always complementary.
- R10: The synchronous active-high reset clears pll_locked and holds clk_out at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Free-running synthesized clock to be gated |
| rst | input | 1 | Synchronous active-high reset |
| cfg_sync_mode | input | 1 | Static mode bit: 0 immediate gating, 1 falling-edge aligned gating |
| pwr_dn_n | input | 1 | Power-down request, active low |
| out_en | input | 1 | Output enable, active high |
| clk_out | output | 1 | Value presented on the clock pin |
| drv_en | output | 1 | Pin driver enable |
| pull_low | output | 1 | Weak pull-low request while the pin is released |
| standby_req | output | 1 | Standby request to oscillator and PLL |
| pll_locked | output | 1 | Relock model has expired and the clock is valid |

## Verification
The two functions that can fall in the same cycle are power-down entry and output-enable, and also relock and output-enable. The bench changes pwr_dn_n and out_en in the same step in both modes and checks that the power-down result wins. It also toggles out_en while the lock counter is still running and checks that the pin stays driven low. In aligned mode, out_en is toggled at every offset within the clock period while a monitor times each high phase of clk_out against half the clock period.

// File: rtl/clk_gate_pkg.sv
package clk_gate_pkg;

    // Pin state chosen by the gate controller
    typedef enum logic [1:0] {
        OUT_OFF = 2'd0,   // released, weak pull low
        OUT_LOW = 2'd1,   // driven, held low
        OUT_CLK = 2'd2    // driven, passing the clock
    } out_mode_e;

    // Active-high view of the two pin controls
    typedef struct packed {
        logic pd;
        logic oe;
    } ctl_req_t;

    // Registered or combinational state that drives the outputs
    typedef struct packed {
        out_mode_e mode;
        logic      standby;
    } gate_state_t;

    // Decoded pin controls
    typedef struct packed {
        logic drv_en;
        logic pull_low;
        logic pass_clk;
    } pin_ctl_t;

    localparam gate_state_t GATE_RST = '{mode: OUT_OFF, standby: 1'b1};

    // Power-down outranks everything, relock outranks output-enable
    function automatic out_mode_e pick_mode(input ctl_req_t req, input logic locked);
        out_mode_e m;
        if (req.pd)       m = OUT_OFF;
        else if (!locked) m = OUT_LOW;
        else if (!req.oe) m = OUT_OFF;
        else              m = OUT_CLK;
        return m;
    endfunction

    function automatic gate_state_t next_state(input ctl_req_t req, input logic locked);
        gate_state_t s;
        s.mode    = pick_mode(req, locked);
        s.standby = req.pd;
        return s;
    endfunction

    function automatic pin_ctl_t decode_mode(input out_mode_e m);
        pin_ctl_t p;
        unique case (m)
            OUT_LOW: p = '{drv_en: 1'b1, pull_low: 1'b0, pass_clk: 1'b0};
            OUT_CLK: p = '{drv_en: 1'b1, pull_low: 1'b0, pass_clk: 1'b1};
            default: p = '{drv_en: 1'b0, pull_low: 1'b1, pass_clk: 1'b0};
        endcase
        return p;
    endfunction

endpackage

// File: rtl/cg_neg_sync.sv
module cg_neg_sync #(
    parameter int              WIDTH   = 2,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(negedge clk) begin
        if (rst) stage_q[0] <= RST_VAL;
        else     stage_q[0] <= d;
    end

    generate
        for (genvar i = 1; i < STAGES; i++) begin : g_stage
            always_ff @(negedge clk) begin
                if (rst) stage_q[i] <= RST_VAL;
                else     stage_q[i] <= stage_q[i-1];
            end
        end
    endgenerate

    assign q = stage_q[STAGES-1];

endmodule

// File: rtl/cg_lock_timer.sv
module cg_lock_timer #(
    parameter int LOCK_CYCLES = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic standby,
    output logic locked
);

    localparam int CNT_W = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LOCK_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             locked_q;

    always_ff @(posedge clk) begin
        if (rst || standby) begin
            cnt_q    <= '0;
            locked_q <= 1'b0;
        end else if (!locked_q) begin
            if (cnt_q == CNT_LAST) locked_q <= 1'b1;
            else                   cnt_q    <= cnt_q + 1'b1;
        end
    end

    assign locked = locked_q;

    // R1: standby always drops the lock
    a_r1_standby_drops_lock: assert property (@(posedge clk) disable iff (rst)
        standby |=> !locked_q);

    // R6: lock only appears once the count has reached its last value
    a_r6_lock_after_count: assert property (@(posedge clk) disable iff (rst)
        $rose(locked_q) |-> ($past(cnt_q) == CNT_LAST));

endmodule

// File: rtl/cg_gate_stage.sv
module cg_gate_stage
    import clk_gate_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sync_mode,
    input  gate_state_t async_st,
    input  gate_state_t sync_nxt,
    output gate_state_t state
);

    gate_state_t aligned_q;

    // Aligned state changes only on the falling edge, while the clock is low
    always_ff @(negedge clk) begin
        if (rst) aligned_q <= GATE_RST;
        else     aligned_q <= sync_nxt;
    end

    assign state = sync_mode ? aligned_q : async_st;

    // Copy of the aligned state taken at the rising edge, for the check below
    gate_state_t high_snap_q;
    always_ff @(posedge clk) high_snap_q <= aligned_q;

    // R4: the aligned state is unchanged across every high phase
    a_r4_stable_while_high: assert property (@(negedge clk) disable iff (rst)
        sync_mode |-> (aligned_q == high_snap_q));

endmodule

// File: rtl/clk_gate_ctl.sv
module clk_gate_ctl
    import clk_gate_pkg::*;
#(
    parameter int LOCK_CYCLES = 256,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_ref,
    input  logic rst,
    input  logic cfg_sync_mode,
    input  logic pwr_dn_n,
    input  logic out_en,
    output logic clk_out,
    output logic drv_en,
    output logic pull_low,
    output logic standby_req,
    output logic pll_locked
);

    localparam int REQ_W = $bits(ctl_req_t);
    localparam ctl_req_t REQ_RST = '{pd: 1'b1, oe: 1'b0};

    ctl_req_t    raw_req;
    ctl_req_t    sync_req;
    logic [REQ_W-1:0] sync_bits;
    gate_state_t async_st;
    gate_state_t sync_nxt;
    gate_state_t cur_st;
    pin_ctl_t    pin;
    logic        locked;

    always_comb begin
        raw_req.pd = ~pwr_dn_n;
        raw_req.oe = out_en;
    end

    cg_neg_sync #(
        .WIDTH   (REQ_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (REQ_RST)
    ) u_req_sync (
        .clk (clk_ref),
        .rst (rst),
        .d   (raw_req),
        .q   (sync_bits)
    );

    assign sync_req = ctl_req_t'(sync_bits);

    always_comb begin
        async_st = next_state(raw_req, locked);
        sync_nxt = next_state(sync_req, locked);
    end

    cg_gate_stage u_stage (
        .clk       (clk_ref),
        .rst       (rst),
        .sync_mode (cfg_sync_mode),
        .async_st  (async_st),
        .sync_nxt  (sync_nxt),
        .state     (cur_st)
    );

    cg_lock_timer #(
        .LOCK_CYCLES (LOCK_CYCLES)
    ) u_lock (
        .clk     (clk_ref),
        .rst     (rst),
        .standby (cur_st.standby),
        .locked  (locked)
    );

    assign pin         = decode_mode(cur_st.mode);
    assign clk_out     = clk_ref & pin.pass_clk;
    assign drv_en      = pin.drv_en;
    assign pull_low    = pin.pull_low;
    assign standby_req = cur_st.standby;
    assign pll_locked  = locked;

    // R1: standby releases the pin
    a_r1_standby_releases_pin: assert property (@(posedge clk_ref) disable iff (rst)
        standby_req |-> (!drv_en && pull_low));

    // R2: a released pin without standby only happens with the clock source locked
    a_r2_disable_keeps_lock: assert property (@(posedge clk_ref) disable iff (rst)
        (!drv_en && !standby_req) |-> pll_locked);

    // R6: no high phase leaves the pin before lock
    a_r6_low_until_lock: assert property (@(negedge clk_ref) disable iff (rst)
        !pll_locked |-> !clk_out);

    // R9: driver and pull never agree
    a_r9_drive_pull_exclusive: assert property (@(posedge clk_ref) disable iff (rst)
        drv_en != pull_low);

endmodule

// File: tb/clk_gate_ctl_bench.sv
`timescale 1ns/1ps
module clk_gate_ctl_bench;

    localparam int  CLK_PERIOD = 10;
    localparam real HALF       = CLK_PERIOD / 2.0;
    localparam int  LOCK_N     = 8;
    localparam int  SETTLE     = 14;
    localparam int  NVEC       = 12;

    // bits: [7] sync mode, [6] pwr_dn_n, [5] out_en,
    //       expected [4] drv_en, [3] pull_low, [2] standby_req, [1] pll_locked, [0] clk_out (sampled while clk high)
    localparam logic [7:0] VECS [NVEC] = '{
        8'b0111_0011,  // immediate: running
        8'b0100_1010,  // immediate: output disabled
        8'b0111_0011,  // immediate: running again
        8'b0100_1010,  // immediate: disabled
        8'b0010_1100,  // immediate: power-down and enable change together
        8'b0111_0011,  // immediate: relocked and running
        8'b1111_0011,  // aligned: running
        8'b1100_1010,  // aligned: disabled
        8'b1010_1100,  // aligned: power-down and enable change together
        8'b1000_1100,  // aligned: power-down, enable low
        8'b1111_0011,  // aligned: relocked and running
        8'b1100_1010   // aligned: disabled
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_sync_mode = 1'b0;
    logic pwr_dn_n = 1'b1;
    logic out_en = 1'b1;
    logic clk_out, drv_en, pull_low, standby_req, pll_locked;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    clk_gate_ctl #(
        .LOCK_CYCLES (LOCK_N),
        .SYNC_STAGES (2)
    ) u_clk_gate_ctl (
        .clk_ref       (clk),
        .rst           (rst),
        .cfg_sync_mode (cfg_sync_mode),
        .pwr_dn_n      (pwr_dn_n),
        .out_en        (out_en),
        .clk_out       (clk_out),
        .drv_en        (drv_en),
        .pull_low      (pull_low),
        .standby_req   (standby_req),
        .pll_locked    (pll_locked)
    );

    // High phase monitor for clk_out
    realtime rise_t = 0.0;
    realtime last_w = 0.0;
    logic    mon_en = 1'b0;
    int      pulses = 0;
    int      short_pulses = 0;

    always @(posedge clk_out) rise_t = $realtime;
    always @(negedge clk_out) begin
        last_w = $realtime - rise_t;
        if (mon_en) begin
            pulses++;
            if (last_w < HALF - 0.01) short_pulses++;
        end
    end

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic sync_m, input logic pdn, input logic oe);
        @(posedge clk); #1;
        rst = 1'b1;
        cfg_sync_mode = sync_m;
        pwr_dn_n = pdn;
        out_en = oe;
        cycles(3);
        rst = 1'b0;
    endtask

    function automatic string vec_tag(input logic [7:0] v);
        if (v[2])      return "R1";
        else if (!v[4]) return "R2";
        else           return "R6";
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        checks++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        // R10: reset state
        cycles(2);
        check(pll_locked == 1'b0, "R10", "pll_locked in reset", int'(pll_locked), 0);
        check(clk_out == 1'b0, "R10", "clk_out in reset", int'(clk_out), 0);
        rst = 1'b0;

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            logic [7:0] v;
            logic [4:0] got;
            v = VECS[i];
            if (v[7] != cfg_sync_mode) do_reset(v[7], v[6], v[5]);
            @(posedge clk); #1;
            pwr_dn_n = v[6];
            out_en   = v[5];
            cycles(SETTLE);
            got = {drv_en, pull_low, standby_req, pll_locked, clk_out};
            check(got == v[4:0], vec_tag(v), $sformatf("vector %0d outputs", i),
                  int'(got), int'(v[4:0]));
            if (i == 4 || i == 8)
                check(got == v[4:0], "R7", $sformatf("vector %0d power-down wins", i),
                      int'(got), int'(v[4:0]));
            check(drv_en != pull_low, "R9", $sformatf("vector %0d drive/pull", i),
                  int'(drv_en), int'(!pull_low));
        end

        // R6 and R8: exact relock timing, enable ignored while relocking
        do_reset(1'b0, 1'b0, 1'b1);
        cycles(2);
        @(posedge clk); #1;
        pwr_dn_n = 1'b1;
        cycles(3);
        out_en = 1'b0;
        #0.5;
        check(drv_en == 1'b1 && pull_low == 1'b0, "R8", "enable ignored before lock",
              int'(drv_en), 1);
        out_en = 1'b1;
        cycles(4);
        check(pll_locked == 1'b0, "R6", "no lock one cycle early", int'(pll_locked), 0);
        check(clk_out == 1'b0 && drv_en == 1'b1, "R6", "pin driven low before lock",
              int'(clk_out), 0);
        cycles(1);
        check(pll_locked == 1'b1, "R6", "lock at count end", int'(pll_locked), 1);
        check(clk_out == 1'b1, "R6", "clock passes after lock", int'(clk_out), 1);

        // R3: immediate mode acts mid high phase
        @(posedge clk); #2;
        out_en = 1'b0;
        #0.5;
        check(clk_out == 1'b0 && drv_en == 1'b0, "R3", "immediate disable",
              int'(clk_out), 0);
        @(posedge clk); #2;
        out_en = 1'b1;
        #0.5;
        check(clk_out == 1'b1, "R3", "immediate enable partial pulse", int'(clk_out), 1);
        @(posedge clk); #2;
        pwr_dn_n = 1'b0;
        #0.5;
        check(standby_req == 1'b1 && clk_out == 1'b0, "R3", "immediate power-down",
              int'(standby_req), 1);
        cycles(1);
        check(pll_locked == 1'b0, "R1", "lock cleared by power-down", int'(pll_locked), 0);

        // R4: aligned mode delays the change to a falling edge
        do_reset(1'b1, 1'b1, 1'b1);
        cycles(SETTLE);
        @(posedge clk); #1;
        out_en = 1'b0;
        #1;
        check(drv_en == 1'b1 && clk_out == 1'b1, "R4", "no immediate disable",
              int'(drv_en), 1);
        cycles(1);
        check(drv_en == 1'b1, "R4", "still driving before third falling edge",
              int'(drv_en), 1);
        cycles(2);
        check(drv_en == 1'b0 && pull_low == 1'b1, "R4", "disabled after third falling edge",
              int'(drv_en), 0);

        // R5: first pulse after re-enable, requested mid high phase
        mon_en = 1'b1;
        @(posedge clk); #2;
        out_en = 1'b1;
        @(negedge clk_out);
        #0.1;
        check(last_w > HALF - 0.01, "R5", "first pulse width ps",
              int'(last_w * 1000.0), int'(HALF * 1000.0));

        // R4: sweep control changes across every offset of the period
        for (int k = 0; k < 36; k++) begin
            @(posedge clk);
            #(0.5 + (k % 9) + 0.25 * (k % 4));
            out_en = ~out_en;
            if (k % 7 == 6) pwr_dn_n = ~pwr_dn_n;
        end
        pwr_dn_n = 1'b1;
        out_en = 1'b1;
        cycles(SETTLE);
        mon_en = 1'b0;
        check(short_pulses == 0, "R4", "short high phases", short_pulses, 0);
        check(pulses > 0, "R4", "pulses seen in sweep", pulses, 1);
        check(clk_out == 1'b1 && drv_en == 1'b1, "R4", "running after sweep",
              int'(clk_out), 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule